// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences a 10-bit successive-approximation converter. Software writes a control word that holds an enable bit, a start bit and a 3-bit acquisition code. Hardware can also start a conversion through a trigger from a compare unit. After a start, the sequencer runs an optional acquisition period measured in conversion-clock ticks (`tad_tick_i`). It then opens the sample switch and resolves one result bit per tick, most significant bit first. For each bit it presents a trial code to the DAC and reads the external comparator.

When the last bit is resolved, four things happen on the same clock edge: the result register loads, the start bit clears, the sticky done flag sets and the sample switch closes. Software can abort a conversion by writing the start bit low. An abort leaves the result register unchanged. Every completion or abort is followed by a fixed recovery gap of two ticks. A start that arrives during a conversion or during the gap is held and acted on when the gap ends.

A compare-unit trigger with the matching mode pulses a timer-reset output. It starts a conversion only while the block is enabled.

Top module: `adc_seq`

## Requirements
- R1: After reset, every output is low and `result_o` is zero, including `go_o`, `en_o`, `busy_o`, `hold_open_o`, `done_flag_o` and `timer_rst_o`.
- R2: The acquisition code `ctrl_acq_i` selects an acquisition time of 0, 2, 4, 6, 8, 12, 16 or 20 ticks for codes 0 through 7.
  - During acquisition `busy_o` is 1 and `hold_open_o` is 0.
  - With code 0, conversion starts on the clock edge that accepts the start.
- R3: A conversion lasts exactly 11 ticks, during all of which `hold_open_o` is 1.
  - Bits are decided MSB first on the first 10 ticks.
  - `cmp_i`=1 means the input is at or above `dac_code_o`, and the trial bit is kept.
  - The final result therefore equals the sampled input code.
- R4: On the edge of the 11th conversion tick, all of these happen together: `result_o` loads, `go_o` clears, `done_flag_o` sets and `hold_open_o` falls.
- R5: Writing the control word with enable=1 and start=0 during acquisition or conversion aborts the run.
  - `go_o` clears.
  - `result_o` keeps its last completed or software-written value.
  - `done_flag_o` is not set.
- R6: After a completion or an abort, `busy_o` stays 1 for a 2-tick gap. A start written during the gap is held, and the next run begins only after the gap.
- R7: A trigger pulse with `trig_mode_i`=4'b1011 while `en_o`=1 sets `go_o` and starts a run, exactly as a software start does.
- R8: `timer_rst_o` pulses for one cycle after any trigger whose mode is 4'b1011, whether the block is enabled or not.
  - When disabled, the trigger does not set `go_o`.
  - A trigger with any other mode does neither.
- R9: A control write that sets enable while `en_o` is 0 does not start a conversion, even when its start bit is 1.
- R10: `res_wr_i` loads `res_wdata_i` into `result_o`. If a completion happens in the same cycle, the completion takes priority.
- R11: `done_flag_o` stays set until `flag_clr_i` is asserted. A clear in the same cycle as a completion wins.
- R12: A control write with enable=0 has the following effects from the next cycle:
  - `go_o` and `en_o` clear.
  - The block returns to idle.
  - `result_o` is unchanged.
- R13: `busy_o` is 1 exactly while the sequencer is in acquisition, conversion or the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tad_tick_i | input | 1 | One-cycle pulse per conversion-clock period |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC trial code |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_enable_i | input | 1 | Enable bit of the control word |
| ctrl_start_i | input | 1 | Start bit of the control word (0 aborts a run) |
| ctrl_acq_i | input | 3 | Acquisition time code |
| res_wr_i | input | 1 | Software write strobe for the result register |
| res_wdata_i | input | 10 | Software result write data |
| flag_clr_i | input | 1 | Clears the done flag |
| trig_pulse_i | input | 1 | Compare-unit event pulse |
| trig_mode_i | input | 4 | Compare-unit mode field |
| go_o | output | 1 | Start/status bit |
| en_o | output | 1 | Enable bit |
| busy_o | output | 1 | Sequencer not idle |
| hold_open_o | output | 1 | Sample switch open (input disconnected) |
| dac_code_o | output | 10 | Trial code for the DAC |
| result_o | output | 10 | Result register |
| done_flag_o | output | 1 | Sticky done interrupt flag |
| timer_rst_o | output | 1 | One-cycle timer reset pulse |

## Verification
The main function is driven by a behavioural comparator that models an analog input. The input codes are all zeros, all ones, single-bit and alternating patterns, the mid-scale neighbours 511 and 512, and random values; each decision that goes the wrong way or lands on the wrong bit shows up as a wrong result. Every acquisition code is exercised once in a directed pass and again at random. Tick counts are taken separately for the acquisition phase and the conversion phase, so that an off-by-one in either period is detected. Completion is also hit with a same-cycle flag clear and a same-cycle software result write to test both priorities. Abort in acquisition, abort in conversion, a start held through the gap, and triggers while enabled, while disabled and with the wrong mode each isolate a single path through the control logic.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_e;

    localparam int ACQ_MAX_TAD = 20;

    // Acquisition length in ticks for each 3-bit code.
    function automatic int acq_tads(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 12;
            3'd6:    return 16;
            default: return ACQ_MAX_TAD;
        endcase
    endfunction

endpackage

// File: rtl/adc_sar_step.sv
module adc_sar_step #(
    parameter int RES_W = 10,
    parameter int IDX_W = 4
) (
    input  logic [RES_W-1:0] sar_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] sar_o
);

    // Keep or drop the bit under trial, then place the next trial bit.
    always_comb begin
        sar_o = sar_i;
        if (!cmp_i) begin
            sar_o[idx_i] = 1'b0;
        end
        if (idx_i != '0) begin
            sar_o[idx_i - 1'b1] = 1'b1;
        end
    end

endmodule

// File: rtl/adc_trig_qual.sv
module adc_trig_qual #(
    parameter int              MODE_W    = 4,
    parameter logic [MODE_W-1:0] TRIG_MODE = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              en_i,
    output logic              take_o,
    output logic              timer_rst_o
);

    logic hit;
    logic timer_rst_d, timer_rst_q;

    always_comb begin
        hit         = trig_i && (mode_i == TRIG_MODE);
        take_o      = hit && en_i;
        timer_rst_d = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_rst_q <= 1'b0;
        end else begin
            timer_rst_q <= timer_rst_d;
        end
    end

    assign timer_rst_o = timer_rst_q;

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int         RES_W     = 10,
    parameter int         GAP_TAD   = 2,
    parameter logic [3:0] TRIG_MODE = 4'b1011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tad_tick_i,
    input  logic             cmp_i,
    input  logic             ctrl_wr_i,
    input  logic             ctrl_enable_i,
    input  logic             ctrl_start_i,
    input  logic [2:0]       ctrl_acq_i,
    input  logic             res_wr_i,
    input  logic [RES_W-1:0] res_wdata_i,
    input  logic             flag_clr_i,
    input  logic             trig_pulse_i,
    input  logic [3:0]       trig_mode_i,
    output logic             go_o,
    output logic             en_o,
    output logic             busy_o,
    output logic             hold_open_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic [RES_W-1:0] result_o,
    output logic             done_flag_o,
    output logic             timer_rst_o
);

    localparam int CONV_TAD = RES_W + 1;
    localparam int CNT_MAX  = (ACQ_MAX_TAD > CONV_TAD) ? ACQ_MAX_TAD : CONV_TAD;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int IDX_W    = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [RES_W-1:0] SAR_INIT = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [RES_W-1:0] sar;
        logic [RES_W-1:0] res;
        logic             go;
        logic             en;
        logic [2:0]       acq;
        logic             flag;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             trig_take;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_W-1:0] sar_next;
    logic             fin, abort, off;

    adc_trig_qual #(
        .MODE_W   (4),
        .TRIG_MODE(TRIG_MODE)
    ) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_pulse_i),
        .mode_i     (trig_mode_i),
        .en_i       (seq_q.en),
        .take_o     (trig_take),
        .timer_rst_o(timer_rst_o)
    );

    assign bit_idx = IDX_W'(RES_W - 1 - int'(seq_q.cnt));

    adc_sar_step #(
        .RES_W(RES_W),
        .IDX_W(IDX_W)
    ) u_step (
        .sar_i(seq_q.sar),
        .idx_i(bit_idx),
        .cmp_i(cmp_i),
        .sar_o(sar_next)
    );

    always_comb begin
        seq_d = seq_q;
        fin   = 1'b0;
        abort = 1'b0;
        off   = 1'b0;

        // Control word write: a turn-on write never starts a run.
        if (ctrl_wr_i) begin
            seq_d.en  = ctrl_enable_i;
            seq_d.acq = ctrl_acq_i;
            if (!ctrl_enable_i) begin
                seq_d.go = 1'b0;
                off      = 1'b1;
            end else if (seq_q.en) begin
                if (ctrl_start_i) begin
                    seq_d.go = 1'b1;
                end else begin
                    seq_d.go = 1'b0;
                    abort    = (seq_q.st == ST_ACQ) || (seq_q.st == ST_CONV);
                end
            end
        end
        if (trig_take && !off) begin
            seq_d.go = 1'b1;
        end

        if (off) begin
            seq_d.st  = ST_IDLE;
            seq_d.cnt = '0;
        end else if (abort) begin
            seq_d.st  = ST_GAP;
            seq_d.cnt = '0;
        end else begin
            case (seq_q.st)
                ST_IDLE: begin
                    if (seq_d.go && seq_d.en) begin
                        seq_d.cnt = '0;
                        if (acq_tads(seq_d.acq) == 0) begin
                            seq_d.st  = ST_CONV;
                            seq_d.sar = SAR_INIT;
                        end else begin
                            seq_d.st = ST_ACQ;
                        end
                    end
                end
                ST_ACQ: begin
                    if (tad_tick_i) begin
                        if (int'(seq_q.cnt) + 1 >= acq_tads(seq_q.acq)) begin
                            seq_d.st  = ST_CONV;
                            seq_d.cnt = '0;
                            seq_d.sar = SAR_INIT;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (tad_tick_i) begin
                        if (int'(seq_q.cnt) == CONV_TAD - 1) begin
                            fin        = 1'b1;
                            seq_d.res  = seq_q.sar;
                            seq_d.go   = 1'b0;
                            seq_d.flag = 1'b1;
                            seq_d.st   = ST_GAP;
                            seq_d.cnt  = '0;
                        end else begin
                            seq_d.sar = sar_next;
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tad_tick_i) begin
                        if (int'(seq_q.cnt) + 1 >= GAP_TAD) begin
                            seq_d.st  = ST_IDLE;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end

        if (res_wr_i && !fin) begin
            seq_d.res = res_wdata_i;
        end
        if (flag_clr_i) begin
            seq_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign go_o        = seq_q.go;
    assign en_o        = seq_q.en;
    assign busy_o      = (seq_q.st != ST_IDLE);
    assign hold_open_o = (seq_q.st == ST_CONV);
    assign dac_code_o  = seq_q.sar;
    assign result_o    = seq_q.res;
    assign done_flag_o = seq_q.flag;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int         RES_W     = 10,
    parameter logic [3:0] TRIG_MODE = 4'b1011
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr_i,
    input logic             ctrl_enable_i,
    input logic             ctrl_start_i,
    input logic             res_wr_i,
    input logic             flag_clr_i,
    input logic             trig_pulse_i,
    input logic [3:0]       trig_mode_i,
    input logic             go_o,
    input logic             en_o,
    input logic             busy_o,
    input logic             hold_open_o,
    input logic [RES_W-1:0] result_o,
    input logic             done_flag_o,
    input logic             timer_rst_o
);

    assert_conv_while_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_open_o |-> (busy_o && go_o));

    assert_done_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag_o) |-> (!go_o && !hold_open_o));

    assert_result_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(hold_open_o) && !$past(res_wr_i)) |-> $stable(result_o));

    assert_gap_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_open_o) && en_o) |-> busy_o);

    assert_timer_rst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timer_rst_o |-> $past(trig_pulse_i && (trig_mode_i == TRIG_MODE)));

    assert_turn_on_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_enable_i && ctrl_start_i && !en_o) |=> !go_o);

    assert_flag_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_i |=> !done_flag_o);

endmodule

bind adc_seq adc_seq_chk #(
    .RES_W    (RES_W),
    .TRIG_MODE(TRIG_MODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_enable_i(ctrl_enable_i),
    .ctrl_start_i (ctrl_start_i),
    .res_wr_i     (res_wr_i),
    .flag_clr_i   (flag_clr_i),
    .trig_pulse_i (trig_pulse_i),
    .trig_mode_i  (trig_mode_i),
    .go_o         (go_o),
    .en_o         (en_o),
    .busy_o       (busy_o),
    .hold_open_o  (hold_open_o),
    .result_o     (result_o),
    .done_flag_o  (done_flag_o),
    .timer_rst_o  (timer_rst_o)
);

// File: tb/adc_seq_bench.sv
module adc_seq_bench;

    localparam int RW      = 10;
    localparam int TAD_DIV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tad_tick = 1'b0;
    logic          cmp;
    logic          ctrl_wr = 1'b0, ctrl_enable = 1'b0, ctrl_start = 1'b0;
    logic [2:0]    ctrl_acq = 3'd0;
    logic          res_wr = 1'b0;
    logic [RW-1:0] res_wdata = '0;
    logic          flag_clr = 1'b0;
    logic          trig_pulse = 1'b0;
    logic [3:0]    trig_mode = 4'd0;
    logic          go, en, busy, hold_open, done_flag, timer_rst;
    logic [RW-1:0] dac_code, result;
    logic [RW-1:0] vin = '0;

    int checks = 0, failures = 0;
    int divc = 0, conv_ticks = 0, bnh_ticks = 0, arm = 0;
    logic [RW-1:0] arm_data = '0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Behavioural comparator: input at or above the trial code.
    assign cmp = (vin >= dac_code);

    adc_seq u_adc_seq (
        .clk(clk), .rst_n(rst_n), .tad_tick_i(tad_tick), .cmp_i(cmp),
        .ctrl_wr_i(ctrl_wr), .ctrl_enable_i(ctrl_enable), .ctrl_start_i(ctrl_start),
        .ctrl_acq_i(ctrl_acq), .res_wr_i(res_wr), .res_wdata_i(res_wdata),
        .flag_clr_i(flag_clr), .trig_pulse_i(trig_pulse), .trig_mode_i(trig_mode),
        .go_o(go), .en_o(en), .busy_o(busy), .hold_open_o(hold_open),
        .dac_code_o(dac_code), .result_o(result), .done_flag_o(done_flag),
        .timer_rst_o(timer_rst)
    );

    function automatic int exp_acq(input logic [2:0] c);
        int t[8] = '{0, 2, 4, 6, 8, 12, 16, 20};
        return t[c];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        logic ph, pb, pt;
        ph = hold_open; pb = busy; pt = tad_tick;
        @(posedge clk);
        #2;
        if (pt && ph) conv_ticks++;
        if (pt && pb && !ph) bnh_ticks++;
        tad_tick = (divc == TAD_DIV - 1);
        divc = (divc + 1) % TAD_DIV;
        if (arm != 0) begin
            bit last;
            last      = hold_open && tad_tick && (conv_ticks == RW);
            flag_clr  = arm[0] && last;
            res_wr    = arm[1] && last;
            res_wdata = arm_data;
        end
    endtask

    task automatic wr_ctrl(input logic e, input logic s, input logic [2:0] a);
        ctrl_wr = 1'b1; ctrl_enable = e; ctrl_start = s; ctrl_acq = a;
        step();
        ctrl_wr = 1'b0;
    endtask

    task automatic fire(input logic [3:0] m);
        trig_pulse = 1'b1; trig_mode = m;
        step();
        trig_pulse = 1'b0;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 600 && go; g++) step();
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 600 && busy; g++) step();
    endtask

    // One full run; mode bit0 clears the flag and bit1 writes the result on the completion edge.
    task automatic run_conv(input logic [2:0] a, input logic [RW-1:0] v, input int mode);
        wait_idle();
        vin = v; conv_ticks = 0; bnh_ticks = 0;
        wr_ctrl(1'b1, 1'b1, a);
        arm = mode; arm_data = ~v;
        wait_done();
        arm = 0; flag_clr = 1'b0; res_wr = 1'b0;
        chk(result == v, (mode >= 2) ? "R10 result" : "R3 result", int'(result), int'(v));
        chk(conv_ticks == RW + 1, "R3 conversion ticks", conv_ticks, RW + 1);
        chk(bnh_ticks == exp_acq(a), "R2 acquisition ticks", bnh_ticks, exp_acq(a));
        chk(done_flag == !mode[0], "R4 R11 flag", int'(done_flag), int'(!mode[0]));
        chk(!hold_open && busy, "R4 R13 hold closed, gap busy", int'({hold_open, busy}), 1);
    endtask

    initial begin
        logic [RW-1:0] pats[8] = '{10'd0, 10'd1023, 10'd512, 10'd511,
                                    10'h2AA, 10'h155, 10'd1, 10'd1022};
        logic [RW-1:0] keep;
        void'($urandom(32'd2024));
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        step();
        chk({go, en, busy, hold_open, done_flag, timer_rst} == 6'b0, "R1 reset outputs",
            int'({go, en, busy, hold_open, done_flag, timer_rst}), 0);
        chk(result == '0, "R1 reset result", int'(result), 0);

        // R9: turn-on write with start set
        wr_ctrl(1'b1, 1'b1, 3'd0);
        chk(!go && en, "R9 turn-on write", int'({go, en}), 1);
        repeat (8) step();
        chk(!busy, "R9 stays idle", int'(busy), 0);

        // R2 R3: every acquisition code with directed patterns
        for (int i = 0; i < 8; i++) run_conv(3'(i), pats[i], 0);

        // R6: start held through the gap
        run_conv(3'd0, 10'd300, 0);
        conv_ticks = 0; bnh_ticks = 0; vin = 10'd77;
        wr_ctrl(1'b1, 1'b1, 3'd0);
        chk(go && busy && !hold_open, "R6 start held in gap", int'({go, busy, hold_open}), 6);
        wait_done();
        chk(bnh_ticks == 2, "R6 gap ticks before next run", bnh_ticks, 2);
        chk(result == 10'd77, "R6 held run result", int'(result), 77);

        // R11: sticky flag and clear
        repeat (5) step();
        chk(done_flag, "R11 flag sticky", int'(done_flag), 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        chk(!done_flag, "R11 flag cleared", int'(done_flag), 0);

        // R5: abort during conversion
        wait_idle();
        vin = 10'd900;
        wr_ctrl(1'b1, 1'b1, 3'd0);
        repeat (12) step();
        chk(hold_open, "R3 converting before abort", int'(hold_open), 1);
        wr_ctrl(1'b1, 1'b0, 3'd0);
        chk(!go && result == 10'd77 && !done_flag, "R5 abort keeps result",
            int'(result), 77);
        chk(busy && !hold_open, "R6 gap after abort", int'({busy, hold_open}), 2);
        bnh_ticks = 0;
        wait_idle();
        chk(bnh_ticks == 2, "R6 abort gap ticks", bnh_ticks, 2);

        // R10: software write, then abort during acquisition
        res_wr = 1'b1; res_wdata = 10'h155; step(); res_wr = 1'b0;
        chk(result == 10'h155, "R10 software write", int'(result), 'h155);
        wr_ctrl(1'b1, 1'b1, 3'd7);
        repeat (5) step();
        chk(busy && !hold_open, "R2 acquiring", int'({busy, hold_open}), 2);
        wr_ctrl(1'b1, 1'b0, 3'd7);
        chk(result == 10'h155 && !go, "R5 abort in acquisition keeps written value",
            int'(result), 'h155);
        wait_idle();

        // R7 R8: triggers
        vin = 10'd600;
        fire(4'b1011);
        chk(go && timer_rst, "R7 R8 enabled trigger", int'({go, timer_rst}), 3);
        step();
        chk(!timer_rst, "R8 one-cycle pulse", int'(timer_rst), 0);
        wait_done();
        chk(result == 10'd600, "R7 triggered result", int'(result), 600);
        wait_idle();
        fire(4'b1010);
        chk(!timer_rst && !go, "R8 wrong mode ignored", int'({go, timer_rst}), 0);

        // R12: disable mid-run
        wr_ctrl(1'b1, 1'b1, 3'd0);
        repeat (10) step();
        wr_ctrl(1'b0, 1'b0, 3'd0);
        chk({go, en, busy, hold_open} == 4'b0, "R12 disable stops", int'({go, en, busy, hold_open}), 0);
        chk(result == 10'd600, "R12 result kept", int'(result), 600);
        fire(4'b1011);
        chk(timer_rst && !go, "R8 disabled trigger", int'({go, timer_rst}), 1);
        repeat (6) step();
        chk(!busy, "R8 disabled trigger no run", int'(busy), 0);
        wr_ctrl(1'b0, 1'b1, 3'd0);
        chk(!go, "R12 start while disabled", int'(go), 0);
        wr_ctrl(1'b1, 1'b0, 3'd0);

        // Random runs with completion-edge collisions (R10 R11)
        for (int i = 0; i < 24; i++) begin
            keep = RW'($urandom % 1024);
            run_conv(3'($urandom % 8), keep, int'($urandom % 4));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R13 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule